// File: doc/BRIEF.md
# Sawtooth PWM Timer Channel

A single channel of a general-purpose PWM timer. A 32-bit up-counter runs in sawtooth fashion: it climbs from zero to the value in the period register and then wraps back to zero. Two compare registers each steer one output pin. A five-bit action code per pin sets the pin's level when counting starts, what happens to the pin when the count wraps, and what happens when the count reaches that pin's compare value. Both pins share the one counter, period and prescaler.

Software programs the channel through a word-wide, memory-mapped register port. The register port has byte addresses, one write strobe and a combinational read. A clock prescaler stretches each count step to 4^n timer clocks. The divide setting, like the mode field, is frozen while the counter runs. Software can load the counter only while it is stopped, which lets the count be cleared before a restart.

Top module: `pwm_saw_channel`

## Requirements
- R1: After reset every register reads zero except the period, which reads 0xFFFFFFFF, and both pins are low.
- R2: Registers sit at byte offsets 0x2C (control), 0x30 (direction), 0x34 (pin control), 0x48 (counter), 0x4C + 4*i (compare i, i = 0 for pin A and 1 for pin B) and 0x64 (period). Other offsets read zero.
- R2 (continued): Only the defined bits are stored; all others read zero. Control: run bit 0, mode 18:16, prescaler 26:24. Direction: bits 1:0. Pin control: pin A code 4:0, pin A enable 8, pin B code 20:16, pin B enable 24.
- R3: While running, the counter steps by one on each prescaled tick. A tick that finds the count equal to the period loads zero instead.
- R4: Prescaler code n makes one tick every 4^n timer clocks for n = 0..5. Codes 6 and 7 behave like code 5 (divide by 1024).
- R5: A control write while running updates only the run bit. Mode and prescaler keep their old values.
- R6: A counter write takes effect only while stopped. While running it is ignored.
- R7: Action code bit 4 is the start level. Bits 3:2 act on a wrap and bits 1:0 act on a compare match. Each two-bit action means 00 hold, 01 low, 10 high, 11 toggle. A compare match is a tick that moves the count onto the compare value. A wrap is a tick that returns the count to zero, and it alone acts on that tick.
- R8: A compare value of 0 never acts (the wrap takes that tick), and a compare value above the period never matches. Code 0x07 with compare 0 therefore stays low throughout.
- R9: While stopped, each pin holds its stop level: low for a wrap action of 01, high for 10, and the start level otherwise. The write that starts the counter loads the start level.
- R10: A pin whose enable bit is clear is driven low. Its internal level keeps evolving.
- R11: Both pins follow the one counter, period and prescaler, so clearing the run bit halts both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| out_a | output | 1 | Output pin A (compare 0) |
| out_b | output | 1 | Output pin B (compare 1) |

## Verification
The bench checks what happens when a compare value coincides with the wrap. A design that let the match win at count zero would make compare 0 produce a full-period high pulse instead of none. It also sets a compare value above the period, where a wrong design would toggle after the count wrapped past its width or match a stale value. The bench writes the prescaler and the counter while the counter is running, where a faulty write gate would change the PWM frequency or jump the count mid-cycle. It runs code 7 to catch a divider that overflows instead of clamping at 1024. It also runs a disabled pin next to an enabled one that shares the counter, and checks each stop level against its action code, where a wrong stop path would leave a pin stuck at its last toggled level.

// File: rtl/pwm_saw_pkg.sv
package pwm_saw_pkg;

  // Register byte offsets (software-visible layout)
  localparam logic [7:0] OFS_CTRL = 8'h2C;
  localparam logic [7:0] OFS_DIR  = 8'h30;
  localparam logic [7:0] OFS_PIN  = 8'h34;
  localparam logic [7:0] OFS_CNT  = 8'h48;
  localparam logic [7:0] OFS_CMP0 = 8'h4C;
  localparam logic [7:0] OFS_PER  = 8'h64;

  // Control field positions
  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_MODE_LSB = 16;
  localparam int unsigned CTRL_PSC_LSB  = 24;

  // Pin control layout: one 16-bit lane per pin
  localparam int unsigned PIN_LANE   = 16;
  localparam int unsigned PIN_EN_OFS = 8;
  localparam int unsigned CODE_W     = 5;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;

  typedef struct packed {
    logic     start_lvl;  // bit 4
    pin_act_e wrap_act;   // bits 3:2
    pin_act_e hit_act;    // bits 1:0
  } pin_code_t;

  function automatic logic act_apply(input pin_act_e act, input logic cur);
    unique case (act)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  function automatic logic park_level(input pin_code_t c);
    if (c.wrap_act == ACT_LOW)  return 1'b0;
    if (c.wrap_act == ACT_HIGH) return 1'b1;
    return c.start_lvl;
  endfunction

endpackage

// File: rtl/pwm_saw_regs.sv
module pwm_saw_regs
  import pwm_saw_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_CMP = 2,
  parameter int unsigned PSC_W   = 3,
  parameter int unsigned MODE_W  = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [7:0]                        bus_addr,
  input  logic                              bus_we,
  input  logic [31:0]                       bus_wdata,
  input  logic [CNT_W-1:0]                  cnt_val,
  output logic                              run,
  output logic [PSC_W-1:0]                  presc,
  output pin_code_t [NUM_CMP-1:0]           code,
  output logic [NUM_CMP-1:0]                oen,
  output logic [NUM_CMP-1:0][CNT_W-1:0]     cmp,
  output logic [CNT_W-1:0]                  period,
  output logic                              cnt_wr,
  output logic                              start,
  output logic [31:0]                       bus_rdata
);

  logic                          run_q, run_d;
  logic [MODE_W-1:0]             mode_q, mode_d;
  logic [PSC_W-1:0]              psc_q, psc_d;
  logic [1:0]                    dir_q, dir_d;
  pin_code_t [NUM_CMP-1:0]       code_q, code_d;
  logic [NUM_CMP-1:0]            oen_q, oen_d;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0]              per_q, per_d;

  logic sel_ctrl, sel_dir, sel_pin, sel_per;
  logic [NUM_CMP-1:0] sel_cmp;

  always_comb begin
    sel_ctrl = bus_we && (bus_addr == OFS_CTRL);
    sel_dir  = bus_we && (bus_addr == OFS_DIR);
    sel_pin  = bus_we && (bus_addr == OFS_PIN);
    sel_per  = bus_we && (bus_addr == OFS_PER);
    for (int i = 0; i < NUM_CMP; i++)
      sel_cmp[i] = bus_we && (bus_addr == 8'(OFS_CMP0 + 4 * i));
  end

  // next-state
  always_comb begin
    run_d  = sel_ctrl ? bus_wdata[CTRL_RUN_BIT] : run_q;
    mode_d = (sel_ctrl && !run_q) ? bus_wdata[CTRL_MODE_LSB +: MODE_W] : mode_q;
    psc_d  = (sel_ctrl && !run_q) ? bus_wdata[CTRL_PSC_LSB +: PSC_W] : psc_q;
    dir_d  = sel_dir ? bus_wdata[1:0] : dir_q;
    per_d  = sel_per ? bus_wdata[CNT_W-1:0] : per_q;
    for (int i = 0; i < NUM_CMP; i++) begin
      code_d[i] = sel_pin ? pin_code_t'(bus_wdata[i*PIN_LANE +: CODE_W]) : code_q[i];
      oen_d[i]  = sel_pin ? bus_wdata[i*PIN_LANE + PIN_EN_OFS] : oen_q[i];
      cmp_d[i]  = sel_cmp[i] ? bus_wdata[CNT_W-1:0] : cmp_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= '0;
      psc_q  <= '0;
      dir_q  <= '0;
      code_q <= '0;
      oen_q  <= '0;
      cmp_q  <= '0;
      per_q  <= '1;
    end else begin
      run_q  <= run_d;
      mode_q <= mode_d;
      psc_q  <= psc_d;
      dir_q  <= dir_d;
      code_q <= code_d;
      oen_q  <= oen_d;
      cmp_q  <= cmp_d;
      per_q  <= per_d;
    end
  end

  assign run    = run_q;
  assign presc  = psc_q;
  assign code   = code_q;
  assign oen    = oen_q;
  assign cmp    = cmp_q;
  assign period = per_q;
  assign cnt_wr = bus_we && (bus_addr == OFS_CNT) && !run_q;
  assign start  = sel_ctrl && bus_wdata[CTRL_RUN_BIT] && !run_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[CTRL_RUN_BIT]                 = run_q;
        bus_rdata[CTRL_MODE_LSB +: MODE_W]      = mode_q;
        bus_rdata[CTRL_PSC_LSB +: PSC_W]        = psc_q;
      end
      OFS_DIR: bus_rdata[1:0] = dir_q;
      OFS_PIN: begin
        for (int i = 0; i < NUM_CMP; i++) begin
          bus_rdata[i*PIN_LANE +: CODE_W]        = code_q[i];
          bus_rdata[i*PIN_LANE + PIN_EN_OFS]     = oen_q[i];
        end
      end
      OFS_CNT: bus_rdata[CNT_W-1:0] = cnt_val;
      OFS_PER: bus_rdata[CNT_W-1:0] = per_q;
      default: begin
        for (int i = 0; i < NUM_CMP; i++)
          if (bus_addr == 8'(OFS_CMP0 + 4 * i)) bus_rdata[CNT_W-1:0] = cmp_q[i];
      end
    endcase
  end

endmodule

// File: rtl/pwm_saw_presc.sv
module pwm_saw_presc #(
  parameter int unsigned PSC_W    = 3,
  parameter int unsigned MAX_CODE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);

  localparam int unsigned PC_W = 2 * MAX_CODE;

  logic [PC_W-1:0] pc_q, pc_d;
  logic [PSC_W-1:0] eff;
  logic [PC_W:0]    limit;

  always_comb begin
    eff   = (code > PSC_W'(MAX_CODE)) ? PSC_W'(MAX_CODE) : code;
    limit = ((PC_W+1)'(1) << (2 * eff)) - (PC_W+1)'(1);
    tick  = run && ({1'b0, pc_q} == limit);
    if (!run)      pc_d = '0;
    else if (tick) pc_d = '0;
    else           pc_d = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

endmodule

// File: rtl/pwm_saw_counter.sv
module pwm_saw_counter #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_CMP = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [CNT_W-1:0]              period,
  input  logic [NUM_CMP-1:0][CNT_W-1:0] cmp,
  input  logic                          wr,
  input  logic [CNT_W-1:0]              wdata,
  output logic [CNT_W-1:0]              cnt,
  output logic                          wrap,
  output logic [NUM_CMP-1:0]            hit
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             cnt_en;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    wrap    = tick && (cnt_q == period);
    for (int i = 0; i < NUM_CMP; i++)
      hit[i] = tick && !wrap && (cnt_inc == cmp[i]);
    cnt_en  = tick || wr;
    if (wrap)      cnt_d = '0;
    else if (tick) cnt_d = cnt_inc;
    else           cnt_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pwm_saw_pin.sv
module pwm_saw_pin
  import pwm_saw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      start,
  input  logic      wrap,
  input  logic      hit,
  input  pin_code_t code,
  input  logic      oen,
  output logic      pin
);

  logic lvl_q, lvl_d;

  always_comb begin
    if (!run)      lvl_d = start ? code.start_lvl : park_level(code);
    else if (wrap) lvl_d = act_apply(code.wrap_act, lvl_q);
    else if (hit)  lvl_d = act_apply(code.hit_act, lvl_q);
    else           lvl_d = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign pin = oen && lvl_q;

endmodule

// File: rtl/pwm_saw_channel.sv
module pwm_saw_channel
  import pwm_saw_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned PSC_W    = 3,
  parameter int unsigned MAX_CODE = 5,
  parameter int unsigned MODE_W   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        out_a,
  output logic        out_b
);

  localparam int unsigned NUM_CMP = 2;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic                          run, tick, cnt_wr, start, wrap;
  logic [PSC_W-1:0]              presc;
  pin_code_t [NUM_CMP-1:0]       code;
  logic [NUM_CMP-1:0]            oen, hit, pins;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp;
  logic [CNT_W-1:0]              period, cnt;

  pwm_saw_regs #(
    .CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .PSC_W(PSC_W), .MODE_W(MODE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .cnt_val(cnt), .run(run), .presc(presc),
    .code(code), .oen(oen), .cmp(cmp), .period(period), .cnt_wr(cnt_wr),
    .start(start), .bus_rdata(bus_rdata)
  );

  pwm_saw_presc #(.PSC_W(PSC_W), .MAX_CODE(MAX_CODE)) u_presc (
    .clk(clk), .rst_n(rst_int_n), .run(run), .code(presc), .tick(tick)
  );

  pwm_saw_counter #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .period(period), .cmp(cmp),
    .wr(cnt_wr), .wdata(bus_wdata[CNT_W-1:0]), .cnt(cnt), .wrap(wrap), .hit(hit)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_pin
    pwm_saw_pin u_pin (
      .clk(clk), .rst_n(rst_int_n), .run(run), .start(start), .wrap(wrap),
      .hit(hit[g]), .code(code[g]), .oen(oen[g]), .pin(pins[g])
    );
  end

  assign out_a = pins[0];
  assign out_b = pins[1];

endmodule

// File: rtl/pwm_saw_channel_chk.sv
module pwm_saw_channel_chk
  import pwm_saw_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PSC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic [PSC_W-1:0] presc,
  input logic [1:0]       oen,
  input logic [1:0]       pins,
  input logic             bus_we,
  input logic [7:0]       bus_addr
);

  // R3: a tick at the period value returns the count to zero
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == period) |=> (cnt == '0));

  // R3: a tick below the period steps by one
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != period) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R6: counter writes while running have no effect
  a_r6_no_load_running: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && bus_we && bus_addr == OFS_CNT) |=> $stable(cnt));

  // R5: divider setting frozen while the counter runs
  a_r5_presc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(presc));

  // R10: disabled pins stay low
  a_r10_pin_a_off: assert property (@(posedge clk) disable iff (!rst_n)
    !oen[0] |-> !pins[0]);
  a_r10_pin_b_off: assert property (@(posedge clk) disable iff (!rst_n)
    !oen[1] |-> !pins[1]);

endmodule

bind pwm_saw_channel pwm_saw_channel_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .run(run), .tick(tick), .cnt(cnt),
  .period(period), .presc(presc), .oen(oen), .pins(pins),
  .bus_we(bus_we), .bus_addr(bus_addr)
);

// File: tb/pwm_saw_channel_tb.sv
`timescale 1ns/1ps
module pwm_saw_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h48;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        out_a, out_b;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_saw_channel u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_a(out_a), .out_b(out_b)
  );

  // ---------------- behavioural reference ----------------
  int          rel = 0;
  bit          m_run;
  int          m_mode, m_psc, m_pc;
  logic [1:0]  m_dir;
  logic [31:0] m_pin, m_cnt, m_per;
  logic [31:0] m_cmp [2];
  bit          m_lvl [2];

  function automatic bit do_act(int a, bit cur);
    if (a == 1) return 0;
    if (a == 2) return 1;
    if (a == 3) return !cur;
    return cur;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h2C: return {5'b0, 3'(m_psc), 5'b0, 3'(m_mode), 15'b0, m_run};
      8'h30: return {30'b0, m_dir};
      8'h34: return m_pin;
      8'h48: return m_cnt;
      8'h4C: return m_cmp[0];
      8'h50: return m_cmp[1];
      8'h64: return m_per;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit in_rst, running, tk, wrp;
    bit hits [2];
    int dv;
    logic [31:0] nc;
    logic [4:0] cd;
    in_rst = (rel < 2) || !rst_n;
    if (!rst_n) rel = 0; else if (rel < 2) rel++;
    if (in_rst) begin
      m_run = 0; m_mode = 0; m_psc = 0; m_pc = 0; m_dir = 0; m_pin = 0;
      m_cnt = 0; m_per = 32'hFFFF_FFFF; m_cmp[0] = 0; m_cmp[1] = 0;
      m_lvl[0] = 0; m_lvl[1] = 0;
    end else begin
      running = m_run;
      dv = 1 << (2 * ((m_psc > 5) ? 5 : m_psc));
      tk = running && (m_pc == dv - 1);
      wrp = 0; hits[0] = 0; hits[1] = 0;
      nc = m_cnt;
      if (tk) begin
        if (m_cnt == m_per) begin wrp = 1; nc = 0; end
        else begin
          nc = m_cnt + 1;
          for (int i = 0; i < 2; i++) hits[i] = (nc == m_cmp[i]);
        end
      end else if (!running && bus_we && bus_addr == 8'h48) nc = bus_wdata;
      m_pc = running ? (tk ? 0 : m_pc + 1) : 0;
      for (int i = 0; i < 2; i++) begin
        cd = m_pin[i*16 +: 5];
        if (!running) begin
          if (bus_we && bus_addr == 8'h2C && bus_wdata[0]) m_lvl[i] = cd[4];
          else if (cd[3:2] == 2'b01) m_lvl[i] = 0;
          else if (cd[3:2] == 2'b10) m_lvl[i] = 1;
          else m_lvl[i] = cd[4];
        end else if (wrp) m_lvl[i] = do_act(int'(cd[3:2]), m_lvl[i]);
        else if (hits[i]) m_lvl[i] = do_act(int'(cd[1:0]), m_lvl[i]);
      end
      if (bus_we) begin
        case (bus_addr)
          8'h2C: begin
            m_run = bus_wdata[0];
            if (!running) begin m_mode = int'(bus_wdata[18:16]); m_psc = int'(bus_wdata[26:24]); end
          end
          8'h30: m_dir = bus_wdata[1:0];
          8'h34: m_pin = bus_wdata & 32'h011F_011F;
          8'h4C: m_cmp[0] = bus_wdata;
          8'h50: m_cmp[1] = bus_wdata;
          8'h64: m_per = bus_wdata;
          default: ;
        endcase
      end
      m_cnt = nc;
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic check(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && rel >= 2 && !done) begin
      check(out_a === (m_lvl[0] && m_pin[8]), {tag, " pin A"}, 32'(out_a), 32'(m_lvl[0] && m_pin[8]));
      check(out_b === (m_lvl[1] && m_pin[24]), {tag, " pin B"}, 32'(out_b), 32'(m_lvl[1] && m_pin[24]));
      check(bus_rdata === m_read(bus_addr), {tag, " readback"}, bus_rdata, m_read(bus_addr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h48;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string t);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(bus_rdata === exp, t, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000", wd);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R1: reset values
    tag = "R1";
    rd_chk(8'h2C, 32'h0, "R1 control");
    rd_chk(8'h30, 32'h0, "R1 direction");
    rd_chk(8'h34, 32'h0, "R1 pin control");
    rd_chk(8'h48, 32'h0, "R1 counter");
    rd_chk(8'h4C, 32'h0, "R1 compare A");
    rd_chk(8'h50, 32'h0, "R1 compare B");
    rd_chk(8'h64, 32'hFFFF_FFFF, "R1 period");
    check(out_a === 1'b0 && out_b === 1'b0, "R1 pins", {30'b0, out_b, out_a}, 32'h0);
    // R2: map and field masking
    tag = "R2";
    wr(8'h30, 32'hFFFF_FFFF);
    rd_chk(8'h30, 32'h3, "R2 direction mask");
    wr(8'h34, 32'hE11B_F107);
    rd_chk(8'h34, 32'h011B_0107, "R2 pin control mask");
    wr(8'h64, 32'd9);
    wr(8'h4C, 32'd3);
    wr(8'h50, 32'd6);
    rd_chk(8'h64, 32'd9, "R2 period");
    rd_chk(8'h4C, 32'd3, "R2 compare A");
    rd_chk(8'h50, 32'd6, "R2 compare B");
    rd_chk(8'h40, 32'h0, "R2 unmapped");
    // R3 R7: basic sawtooth PWM
    tag = "R3 R7";
    wr(8'h2C, 32'h1);
    idle(40);
    // R5: locked fields while running
    tag = "R5";
    wr(8'h2C, 32'h0201_0001);
    rd_chk(8'h2C, 32'h1, "R5 control while running");
    idle(10);
    // R6: counter load ignored while running
    tag = "R6";
    wr(8'h48, 32'h55);
    idle(5);
    // R9 R11: stop both pins to their stop level
    tag = "R9 R11";
    wr(8'h2C, 32'h0);
    idle(3);
    check(out_a === 1'b0, "R9 stop level A", 32'(out_a), 32'h0);
    check(out_b === 1'b1, "R9 stop level B", 32'(out_b), 32'h1);
    // R6: load while stopped
    tag = "R6";
    wr(8'h48, 32'd0);
    rd_chk(8'h48, 32'd0, "R6 counter cleared");
    // R4: divide by 4 then clamp of code 7
    tag = "R4";
    wr(8'h2C, 32'h0100_0001);
    idle(100);
    wr(8'h2C, 32'h0);
    wr(8'h2C, 32'h0700_0000);
    rd_chk(8'h2C, 32'h0700_0000, "R4 prescaler code 7 stored");
    wr(8'h64, 32'd2);
    wr(8'h48, 32'd0);
    wr(8'h2C, 32'h0700_0001);
    idle(7000);
    wr(8'h2C, 32'h0);
    // R8: compare at zero and above the period
    tag = "R8";
    wr(8'h2C, 32'h0);
    wr(8'h64, 32'd7);
    wr(8'h4C, 32'd0);
    wr(8'h50, 32'd20);
    wr(8'h48, 32'd0);
    wr(8'h2C, 32'h1);
    idle(40);
    wr(8'h2C, 32'h0);
    // R10 R11: pin B disabled, pin A with hold on wrap
    tag = "R10 R11";
    wr(8'h34, 32'h001B_0113);
    wr(8'h4C, 32'd4);
    wr(8'h50, 32'd2);
    wr(8'h48, 32'd0);
    wr(8'h2C, 32'h1);
    idle(40);
    check(out_b === 1'b0, "R10 disabled pin", 32'(out_b), 32'h0);
    wr(8'h2C, 32'h0);
    idle(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule